// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is one register-mapped down-counter of 32 bits. It raises a level interrupt when its count runs out. Software sets a reload limit, chooses an expiry behaviour and a tick prescaler, and enables the counter. On every prescaled tick the count drops by one.

The expiry behaviour is one of three. The count can stop at zero. It can wrap to the all-ones value of the selected counter size. It can reload from the limit. A second load register changes the reload limit and leaves the running count alone. This lets software retune the period without disturbing the interval already in progress.

Access is through a single-cycle synchronous word bus. A write takes effect at the clock edge that samples it. Read data is combinational from the register state in the same cycle.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register reads 0x00000020, the count reads 0xFFFFFFFF, the limit reads 0, both status words read 0 and `irq` is low.
- R2: A write to word 0 sets both the limit and the count. Reads of word 0 and of word 6 both return the limit.
- R3: A write to word 6 changes only the limit. The count is untouched, and the next periodic reload uses the new limit.
- R4: While control bit 7 is set, the count drops by one on each prescaled tick. While bit 7 is clear, the count holds.
- R5: With bit 0 clear and bit 6 set, the count reloads from the limit on a tick at which the active count is 1 or 0.
- R6: With bits 0 and 6 both clear, the count wraps on expiry to 0x0000FFFF when bit 1 is clear or to 0xFFFFFFFF when bit 1 is set.
- R7: With bit 0 set, expiry sets the count to 0. An enabled timer of this kind with a zero count neither counts nor raises the flag again.
- R8: With bit 1 clear, only bits 15:0 take part in counting and expiry detection. A decrement leaves bits 31:16 as they were.
- R9: Control bits 3:2 choose the tick rate: 00 and 11 give one tick per clock, 01 one per 16 clocks, and 10 one per 256 clocks. A control write restarts the divider, so the first decrement lands N clocks after that write.
- R10: Expiry sets the raw flag (word 4, bit 0). Any write to word 3 clears it, but an expiry in the same cycle wins.
- R11: The masked status (word 5) and `irq` both equal the raw flag ANDed with control bit 5.
- R12: Writes to word 1 have no effect. Word 1 reads the count and word 2 reads the control value. Words 7 and above read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties rely on three conditions:
- Ticks come only from the divider.
- At most one register access happens per cycle.
- Bit 7 of control gates the divider output.

On that basis, the count may move only on a tick or a load write, and the raw flag may rise only after a tick.

The stimulus changes bus inputs just after a clock edge and holds them for exactly one cycle. It samples read data at the falling edge. It lines up the one coincident case, a flag clear in the same cycle as an expiry, by counting edges from the enabling control write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       irq_en;
        logic       spare;
        logic [1:0] scale;
        logic       wide;
        logic       single;
    } tmr_ctrl_t;

    localparam tmr_ctrl_t CTRL_RST = 8'h20;

    typedef enum logic [2:0] {
        REG_LOAD   = 3'd0,
        REG_VALUE  = 3'd1,
        REG_CTRL   = 3'd2,
        REG_ICLR   = 3'd3,
        REG_RAW    = 3'd4,
        REG_MASK   = 3'd5,
        REG_BGLOAD = 3'd6,
        REG_NONE   = 3'd7
    } tmr_reg_e;

    // terminal value of the tick divider for a scale code
    function automatic logic [7:0] scale_term(input logic [1:0] code);
        case (code)
            2'b01:   scale_term = 8'd15;
            2'b10:   scale_term = 8'd255;
            default: scale_term = 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] scale,
    output logic       tick
);

    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] term;

    assign term = PRE_W'(scale_term(scale));
    assign tick = run && (pcnt == term);

    always_ff @(posedge clk) begin
        if (rst || restart)
            pcnt <= '0;
        else if (pcnt == term)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end

    // R9
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && term != '0 && !restart) |=> !tick);

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             single,
    input  logic             periodic,
    input  logic             wide,
    input  logic             tick,
    input  logic             wr_load,
    input  logic             wr_bg,
    input  logic             wr_clr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit,
    output logic             raw
);

    localparam int HALF_W = CNT_W / 2;

    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] all_ones;
    logic [CNT_W-1:0] dec_val;
    logic [CNT_W-1:0] reload_val;
    logic             parked;
    logic             step;
    logic             expire;

    assign active   = wide ? count : {{HALF_W{1'b0}}, count[HALF_W-1:0]};
    assign all_ones = wide ? {CNT_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    assign dec_val  = wide ? (count - 1'b1)
                           : {count[CNT_W-1:HALF_W], count[HALF_W-1:0] - 1'b1};

    always_comb begin
        if (single)
            reload_val = '0;
        else if (periodic)
            reload_val = limit;
        else
            reload_val = all_ones;
    end

    assign parked = single && (active == '0);
    assign step   = tick && !parked;
    assign expire = step && (active <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '1;
            limit <= '0;
        end else if (wr_load) begin
            count <= wdata;
            limit <= wdata;
        end else begin
            if (wr_bg)
                limit <= wdata;
            if (step)
                count <= expire ? reload_val : dec_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            raw <= 1'b0;
        else if (expire)
            raw <= 1'b1;
        else if (wr_clr)
            raw <= 1'b0;
    end

    // R4 R12
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_load) |=> $stable(count));

    // R7
    oneshot_park_chk: assert property (@(posedge clk) disable iff (rst)
        (single && active == '0 && !wr_load) |=> $stable(count));

    // R10
    raw_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(raw) |-> $past(tick));

    // R10
    raw_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && !tick) |=> !raw);

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] cur_count,
    input  logic [DATA_W-1:0] cur_limit,
    input  logic              raw_flag,
    output tmr_ctrl_t         ctrl,
    output logic              wr_load,
    output logic              wr_bg,
    output logic              wr_ctrl,
    output logic              wr_clr
);

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    logic     addr_hi;
    tmr_reg_e idx;
    logic     wr_any;

    generate
        if (ADDR_W > 3) begin : g_hi
            assign addr_hi = |bus_addr[ADDR_W-1:3];
        end else begin : g_nohi
            assign addr_hi = 1'b0;
        end
    endgenerate

    assign idx    = addr_hi ? REG_NONE : tmr_reg_e'(bus_addr[2:0]);
    assign wr_any = bus_sel && bus_we;

    assign wr_load = wr_any && (idx == REG_LOAD);
    assign wr_bg   = wr_any && (idx == REG_BGLOAD);
    assign wr_ctrl = wr_any && (idx == REG_CTRL);
    assign wr_clr  = wr_any && (idx == REG_ICLR);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= CTRL_RST;
        else if (wr_ctrl)
            ctrl <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (idx)
                REG_LOAD, REG_BGLOAD: bus_rdata = cur_limit;
                REG_VALUE:            bus_rdata = cur_count;
                REG_CTRL:             bus_rdata = DATA_W'(ctrl);
                REG_RAW:              bus_rdata = DATA_W'(raw_flag);
                REG_MASK:             bus_rdata = DATA_W'(raw_flag && ctrl.irq_en);
                default:              bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    tmr_ctrl_t         ctrl;
    logic              wr_load;
    logic              wr_bg;
    logic              wr_ctrl;
    logic              wr_clr;
    logic              tick;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] limit;
    logic              raw;

    tmr_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cur_count (count),
        .cur_limit (limit),
        .raw_flag  (raw),
        .ctrl      (ctrl),
        .wr_load   (wr_load),
        .wr_bg     (wr_bg),
        .wr_ctrl   (wr_ctrl),
        .wr_clr    (wr_clr)
    );

    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (wr_ctrl),
        .run     (ctrl.run),
        .scale   (ctrl.scale),
        .tick    (tick)
    );

    tmr_core #(.CNT_W(DATA_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .single   (ctrl.single),
        .periodic (ctrl.periodic),
        .wide     (ctrl.wide),
        .tick     (tick),
        .wr_load  (wr_load),
        .wr_bg    (wr_bg),
        .wr_clr   (wr_clr),
        .wdata    (bus_wdata),
        .count    (count),
        .limit    (limit),
        .raw      (raw)
    );

    assign irq = raw && ctrl.irq_en;

    // R11
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!raw) |-> !irq);

endmodule

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;

    localparam int DW = 32;
    localparam int AW = 3;

    localparam logic [AW-1:0] A_LOAD = 3'd0;
    localparam logic [AW-1:0] A_VAL  = 3'd1;
    localparam logic [AW-1:0] A_CTRL = 3'd2;
    localparam logic [AW-1:0] A_CLR  = 3'd3;
    localparam logic [AW-1:0] A_RAW  = 3'd4;
    localparam logic [AW-1:0] A_MSK  = 3'd5;
    localparam logic [AW-1:0] A_BG   = 3'd6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    interval_timer dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    // monitor: pops the scoreboard on each read cycle
    always @(negedge clk) begin
        if (bus_sel && !bus_we) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard underflow actual=%h", bus_rdata);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h", t, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, 32'h20, "R1");
        rd(A_VAL, 32'hFFFFFFFF, "R1");
        rd(A_LOAD, 32'h0, "R1");
        rd(A_RAW, 32'h0, "R1");
        rd(A_MSK, 32'h0, "R1");
        chk_irq(1'b0, "R1");
        rd(3'd7, 32'h0, "R12");

        // R2 load, R12 value write ignored
        wr(A_LOAD, 32'd5);
        rd(A_LOAD, 32'd5, "R2");
        rd(A_BG, 32'd5, "R2");
        rd(A_VAL, 32'd5, "R2");
        wr(A_VAL, 32'd123);
        rd(A_VAL, 32'd5, "R12");

        // R4 R5 periodic, 32-bit, irq enabled
        wr(A_CTRL, 32'hE2);
        rd(A_VAL, 32'd5, "R4");
        rd(A_VAL, 32'd4, "R4");
        rd(A_VAL, 32'd3, "R4");
        rd(A_VAL, 32'd2, "R4");
        rd(A_VAL, 32'd1, "R4");
        rd(A_VAL, 32'd5, "R5");
        rd(A_RAW, 32'd1, "R10");
        chk_irq(1'b1, "R11");
        rd(A_MSK, 32'd1, "R11");
        wr(A_CTRL, 32'h22);
        rd(A_VAL, 32'd1, "R4");
        rd(A_VAL, 32'd1, "R4");
        rd(A_CTRL, 32'h22, "R12");
        wr(A_CTRL, 32'h02);
        rd(A_MSK, 32'd0, "R11");
        rd(A_RAW, 32'd1, "R11");
        chk_irq(1'b0, "R11");
        wr(A_CLR, 32'd0);
        rd(A_RAW, 32'd0, "R10");

        // R3 background load
        wr(A_BG, 32'd2);
        rd(A_VAL, 32'd1, "R3");
        rd(A_LOAD, 32'd2, "R3");
        wr(A_CTRL, 32'hC2);
        rd(A_VAL, 32'd1, "R3");
        rd(A_VAL, 32'd2, "R3");
        rd(A_VAL, 32'd1, "R3");
        rd(A_VAL, 32'd2, "R3");
        rd(A_RAW, 32'd1, "R10");
        rd(A_MSK, 32'd0, "R11");
        chk_irq(1'b0, "R11");
        wr(A_CTRL, 32'h02);
        wr(A_CLR, 32'd0);

        // R7 one-shot
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, 32'h83);
        rd(A_VAL, 32'd3, "R7");
        rd(A_VAL, 32'd2, "R7");
        rd(A_VAL, 32'd1, "R7");
        rd(A_VAL, 32'd0, "R7");
        rd(A_VAL, 32'd0, "R7");
        rd(A_VAL, 32'd0, "R7");
        rd(A_RAW, 32'd1, "R7");
        wr(A_CLR, 32'd0);
        rd(A_RAW, 32'd0, "R7");
        rd(A_VAL, 32'd0, "R7");
        wr(A_CTRL, 32'h02);

        // R8 R6 free-running 16-bit
        wr(A_LOAD, 32'hABCD0002);
        wr(A_CTRL, 32'h80);
        rd(A_VAL, 32'hABCD0002, "R8");
        rd(A_VAL, 32'hABCD0001, "R8");
        rd(A_VAL, 32'h0000FFFF, "R6");
        rd(A_VAL, 32'h0000FFFE, "R8");
        wr(A_CTRL, 32'h02);

        // R6 free-running 32-bit
        wr(A_LOAD, 32'd1);
        wr(A_CTRL, 32'h82);
        rd(A_VAL, 32'd1, "R6");
        rd(A_VAL, 32'hFFFFFFFF, "R6");
        rd(A_VAL, 32'hFFFFFFFE, "R6");
        wr(A_CTRL, 32'h02);
        wr(A_CLR, 32'd0);

        // R9 divide by 16
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, 32'h86);
        rd(A_VAL, 32'd3, "R9");
        idle(14);
        rd(A_VAL, 32'd3, "R9");
        rd(A_VAL, 32'd2, "R9");
        idle(14);
        rd(A_VAL, 32'd2, "R9");
        rd(A_VAL, 32'd1, "R9");

        // R9 divide by 256
        wr(A_CTRL, 32'h06);
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, 32'h8A);
        rd(A_VAL, 32'd2, "R9");
        idle(254);
        rd(A_VAL, 32'd2, "R9");
        rd(A_VAL, 32'd1, "R9");

        // R9 code 11 acts as divide by 1
        wr(A_CTRL, 32'h02);
        wr(A_LOAD, 32'd5);
        wr(A_CTRL, 32'h8E);
        rd(A_VAL, 32'd5, "R9");
        rd(A_VAL, 32'd4, "R9");
        wr(A_CTRL, 32'h02);
        wr(A_CLR, 32'd0);
        rd(A_RAW, 32'd0, "R10");

        // R10 expiry beats a same-cycle clear
        wr(A_LOAD, 32'd2);
        wr(A_CTRL, 32'hC2);
        rd(A_VAL, 32'd2, "R10");
        wr(A_CLR, 32'd0);
        rd(A_RAW, 32'd1, "R10");
        wr(A_CTRL, 32'h02);
        wr(A_CLR, 32'd0);
        rd(A_RAW, 32'd0, "R10");

        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule